// File: doc/BRIEF.md
# Suspend Clock Stop Controller

This block sequences the internal clock-gate enables of a chip through a suspend handshake. An active-low suspend request enters from outside and passes through a synchronizer of configurable depth. The controller then switches off the core clock domain first. Depending on a stored suspend-mode bit, it may also switch off the memory and display clock domains. Once every clock that should stop has stopped, it drives an active-low suspend acknowledge.

The mode bit picks one of two suspends. In refresh suspend (mode 0) the memory and display clocks keep running, so the system clock input must stay alive. In stop-all suspend (mode 1) every internal clock is gated off before the acknowledge. A flag then tells the board that the system clock may be removed.

When the request is withdrawn, the acknowledge is released first. The enables then return in the reverse of the order in which they were dropped. The mode bit is written through a one-bit configuration port. Its value is sampled only when a suspend begins.

Top module: `suspend_clk_ctl`

## Requirements
- R1: Out of reset, all core and memory/display enables are 1, suspAckN is 1 and sysClkStopOk is 0.
- R2: The stored mode bit resets to 0 (refresh), so a suspend with no prior configuration write leaves the memory/display enables on.
- R3: The core enables go to 0 on the (SYNC_STAGES+1)-th rising edge after suspReqN is first sampled low.
- R4: In mode 0 (cfgWrData=0 at entry) the memory/display enables stay 1 for the whole suspend.
- R5: In mode 1 (cfgWrData=1 at entry) the memory/display enables go to 0 exactly one cycle after the core enables.
- R6: suspAckN goes low in the cycle after the last enable of the selected mode drops. While suspAckN is low, the core enables are 0.
- R7: sysClkStopOk is 1 exactly while suspAckN is low in a mode-1 suspend, and 0 at all other times.
- R8: The first edge at which the synchronized request is seen deasserted while acknowledged raises suspAckN. All enables are still unchanged in that cycle.
- R9: One cycle after suspAckN rises, the memory/display enables are 1. One cycle after that, the core enables are 1.
- R10: A request withdrawn before the acknowledge does not abort the entry. The acknowledge still asserts, for a single cycle, and then the release of R8 and R9 follows.
- R11: A mode write made while suspended does not affect the current suspend. It takes effect at the next suspend entry.
- R12: All bits of coreClkEn carry one value, and all bits of memClkEn carry one value, at every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| suspReqN | input | 1 | Active-low suspend request (asynchronous, synchronized inside) |
| cfgWrEn | input | 1 | Write strobe for the suspend-mode bit |
| cfgWrData | input | 1 | Mode value to write: 0 refresh suspend, 1 stop-all suspend |
| coreClkEn | output | NUM_CORE | Gate enables for the core clock domain |
| memClkEn | output | NUM_MEMD | Gate enables for the memory and display clock domains |
| suspAckN | output | 1 | Active-low suspend acknowledge |
| sysClkStopOk | output | 1 | High when the system clock input may be stopped |

## Verification
The bench builds the block with SYNC_STAGES=2, NUM_CORE=2 and NUM_MEMD=3. The synchronizer latency is therefore part of every expected edge count. The multi-bit enable groups also expose any bit that moves out of step with its group.

In both modes, the bench sweeps the request hold length from one cycle to nine. Short holds withdraw the request at each point of the entry sequence, before the acknowledge. Long holds withdraw it well after the acknowledge. For every cycle of every run, all four outputs are compared against closed-form edge positions.

Further runs cover the reset default and mode flips written in the middle of a suspend.

// File: rtl/suspclk_pkg.sv
package suspclk_pkg;

  typedef enum logic [2:0] {
    ST_RUN       = 3'd0,
    ST_CORE_OFF  = 3'd1,
    ST_MEM_OFF   = 3'd2,
    ST_SUSP      = 3'd3,
    ST_WAKE_MEM  = 3'd4,
    ST_WAKE_CORE = 3'd5
  } seqState_t;

  // One-cycle strobes from the sequencer to the datapath
  typedef struct packed {
    logic latchMode;
    logic dropCore;
    logic dropMem;
    logic setAck;
    logic clrAck;
    logic wakeMem;
    logic wakeCore;
  } seqStrobe_t;

endpackage

// File: rtl/suspclk_ctrl.sv
module suspclk_ctrl
  import suspclk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqSeen,
  input  logic       modeLatched,
  output seqStrobe_t strobe
);

  seqState_t state;
  seqState_t nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      ST_RUN: begin
        if (reqSeen) begin
          strobe.latchMode = 1'b1;
          strobe.dropCore  = 1'b1;
          nextState        = ST_CORE_OFF;
        end
      end
      ST_CORE_OFF: begin
        if (modeLatched) begin
          strobe.dropMem = 1'b1;
          nextState      = ST_MEM_OFF;
        end else begin
          strobe.setAck = 1'b1;
          nextState     = ST_SUSP;
        end
      end
      ST_MEM_OFF: begin
        strobe.setAck = 1'b1;
        nextState     = ST_SUSP;
      end
      ST_SUSP: begin
        if (!reqSeen) begin
          strobe.clrAck = 1'b1;
          nextState     = ST_WAKE_MEM;
        end
      end
      ST_WAKE_MEM: begin
        strobe.wakeMem = 1'b1;
        nextState      = ST_WAKE_CORE;
      end
      ST_WAKE_CORE: begin
        strobe.wakeCore = 1'b1;
        nextState       = ST_RUN;
      end
      default: nextState = ST_RUN;
    endcase
  end

endmodule

// File: rtl/suspclk_datapath.sv
module suspclk_datapath
  import suspclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NUM_CORE    = 2,
  parameter int NUM_MEMD    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                suspReqN,
  input  logic                cfgWrEn,
  input  logic                cfgWrData,
  input  seqStrobe_t          strobe,
  output logic                reqSeen,
  output logic                modeLatched,
  output logic [NUM_CORE-1:0] coreClkEn,
  output logic [NUM_MEMD-1:0] memClkEn,
  output logic                suspAckN,
  output logic                sysClkStopOk
);

  logic cfgReg;
  logic coreOn;
  logic memOn;
  logic ackOn;
  logic stopOk;

  // Request synchronizer, depth picked by parameter
  generate
    if (SYNC_STAGES == 0) begin : g_noSync
      assign reqSeen = ~suspReqN;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] syncQ;
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
          always_ff @(posedge clk or negedge rstN) begin
            if (!rstN) syncQ[0] <= 1'b0;
            else       syncQ[0] <= ~suspReqN;
          end
        end else begin : g_next
          always_ff @(posedge clk or negedge rstN) begin
            if (!rstN) syncQ[i] <= 1'b0;
            else       syncQ[i] <= syncQ[i-1];
          end
        end
      end
      assign reqSeen = syncQ[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg      <= 1'b0;
      modeLatched <= 1'b0;
      coreOn      <= 1'b1;
      memOn       <= 1'b1;
      ackOn       <= 1'b0;
      stopOk      <= 1'b0;
    end else begin
      if (cfgWrEn)          cfgReg      <= cfgWrData;
      if (strobe.latchMode) modeLatched <= cfgReg;
      if (strobe.dropCore)  coreOn      <= 1'b0;
      else if (strobe.wakeCore) coreOn  <= 1'b1;
      if (strobe.dropMem)   memOn       <= 1'b0;
      else if (strobe.wakeMem) memOn    <= 1'b1;
      if (strobe.setAck) begin
        ackOn  <= 1'b1;
        stopOk <= modeLatched;
      end else if (strobe.clrAck) begin
        ackOn  <= 1'b0;
        stopOk <= 1'b0;
      end
    end
  end

  generate
    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
      assign coreClkEn[c] = coreOn;
    end
    for (genvar m = 0; m < NUM_MEMD; m++) begin : g_mem
      assign memClkEn[m] = memOn;
    end
  endgenerate

  assign suspAckN     = ~ackOn;
  assign sysClkStopOk = stopOk;

endmodule

// File: rtl/suspend_clk_ctl.sv
module suspend_clk_ctl
  import suspclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NUM_CORE    = 2,
  parameter int NUM_MEMD    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                suspReqN,
  input  logic                cfgWrEn,
  input  logic                cfgWrData,
  output logic [NUM_CORE-1:0] coreClkEn,
  output logic [NUM_MEMD-1:0] memClkEn,
  output logic                suspAckN,
  output logic                sysClkStopOk
);

  seqStrobe_t strobe;
  logic       reqSeen;
  logic       modeLatched;

  suspclk_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqSeen     (reqSeen),
    .modeLatched (modeLatched),
    .strobe      (strobe)
  );

  suspclk_datapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .NUM_CORE    (NUM_CORE),
    .NUM_MEMD    (NUM_MEMD)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .suspReqN     (suspReqN),
    .cfgWrEn      (cfgWrEn),
    .cfgWrData    (cfgWrData),
    .strobe       (strobe),
    .reqSeen      (reqSeen),
    .modeLatched  (modeLatched),
    .coreClkEn    (coreClkEn),
    .memClkEn     (memClkEn),
    .suspAckN     (suspAckN),
    .sysClkStopOk (sysClkStopOk)
  );

endmodule

// File: rtl/suspend_clk_ctl_chk.sv
module suspend_clk_ctl_chk #(
  parameter int NUM_CORE = 2,
  parameter int NUM_MEMD = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_CORE-1:0] coreClkEn,
  input logic [NUM_MEMD-1:0] memClkEn,
  input logic                suspAckN,
  input logic                sysClkStopOk
);

  localparam logic [NUM_CORE-1:0] CORE_ALL = {NUM_CORE{1'b1}};
  localparam logic [NUM_MEMD-1:0] MEM_ALL  = {NUM_MEMD{1'b1}};

  assert_core_off_while_acked_R6: assert property (@(posedge clk) disable iff (!rstN)
    !suspAckN |-> coreClkEn == '0);

  assert_ack_after_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(suspAckN) |-> $past(coreClkEn == '0));

  assert_stop_ok_only_all_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    sysClkStopOk |-> (!suspAckN && memClkEn == '0));

  assert_refresh_keeps_mem_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!suspAckN && !sysClkStopOk) |-> memClkEn == MEM_ALL);

  assert_mem_after_core_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memClkEn[0]) |-> $past(coreClkEn[0] == 1'b0));

  assert_ack_release_first_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(suspAckN) |-> coreClkEn == '0);

  assert_mem_before_core_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreClkEn[0]) |-> (memClkEn == MEM_ALL && $past(memClkEn[0])));

  assert_group_uniform_R12: assert property (@(posedge clk) disable iff (!rstN)
    (coreClkEn == '0 || coreClkEn == CORE_ALL) && (memClkEn == '0 || memClkEn == MEM_ALL));

endmodule

bind suspend_clk_ctl suspend_clk_ctl_chk #(
  .NUM_CORE (NUM_CORE),
  .NUM_MEMD (NUM_MEMD)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .coreClkEn    (coreClkEn),
  .memClkEn     (memClkEn),
  .suspAckN     (suspAckN),
  .sysClkStopOk (sysClkStopOk)
);

// File: tb/tb_suspend_clk_ctl.sv
`timescale 1ns/1ps
module tb_suspend_clk_ctl;

  localparam int S  = 2;
  localparam int NC = 2;
  localparam int NM = 3;
  localparam logic [7:0] CORE_ON = 8'((1 << NC) - 1);
  localparam logic [7:0] MEM_ON  = 8'((1 << NM) - 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          suspReqN = 1'b1;
  logic          cfgWrEn = 1'b0;
  logic          cfgWrData = 1'b0;
  logic [NC-1:0] coreClkEn;
  logic [NM-1:0] memClkEn;
  logic          suspAckN;
  logic          sysClkStopOk;

  int  errors = 0;
  int  checks = 0;
  bit  done   = 1'b0;

  always #2 clk = ~clk;

  suspend_clk_ctl #(.SYNC_STAGES(S), .NUM_CORE(NC), .NUM_MEMD(NM)) dut (
    .clk(clk), .rstN(rstN), .suspReqN(suspReqN), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .coreClkEn(coreClkEn), .memClkEn(memClkEn),
    .suspAckN(suspAckN), .sysClkStopOk(sysClkStopOk)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic setMode(input bit v);
    cfgWrEn = 1'b1; cfgWrData = v;
    @(posedge clk); @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // One suspend run: request held for 'hold' edges; optional mode flip while acked
  task automatic runScenario(input bit m, input int hold, input bit flip, input string lbl);
    int a, r;
    bit coreOff, memOff, acked;
    a = S + 2 + int'(m);
    r = (a + 1 > hold + S + 1) ? a + 1 : hold + S + 1;
    suspReqN = 1'b0;
    for (int t = 0; t <= r + 4; t++) begin
      if (t > 0) begin
        @(posedge clk); @(negedge clk);
        cfgWrEn = 1'b0;
      end
      coreOff = (t >= S + 1) && (t < r + 2);
      memOff  = m && (t >= S + 2) && (t < r + 1);
      acked   = (t >= a) && (t < r);
      chk($sformatf("%s core R3 R9 R12 t=%0d", lbl, t), 8'(coreClkEn), coreOff ? 8'h00 : CORE_ON);
      chk($sformatf("%s mem %s R9 R12 t=%0d", lbl, m ? "R5" : "R4", t), 8'(memClkEn), memOff ? 8'h00 : MEM_ON);
      chk($sformatf("%s ack R6 R8 R10 t=%0d", lbl, t), 8'(suspAckN), acked ? 8'h00 : 8'h01);
      chk($sformatf("%s stopOk R7 t=%0d", lbl, t), 8'(sysClkStopOk), (m && acked) ? 8'h01 : 8'h00);
      if (t == hold) suspReqN = 1'b1;
      if (flip && t == a) begin cfgWrEn = 1'b1; cfgWrData = ~m; end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    chk("R1 core", 8'(coreClkEn), CORE_ON);
    chk("R1 mem", 8'(memClkEn), MEM_ON);
    chk("R1 ack", 8'(suspAckN), 8'h01);
    chk("R1 stopOk", 8'(sysClkStopOk), 8'h00);
    // R2: no write yet, mode must be refresh
    runScenario(1'b0, 6, 1'b0, "R2 default");
    // Sweep of hold lengths in both modes (R10 for short holds)
    for (int mi = 0; mi < 2; mi++) begin
      setMode(mi[0]);
      for (int h = 1; h <= 9; h++)
        runScenario(mi[0], h, 1'b0, $sformatf("sweep m=%0d h=%0d", mi, h));
    end
    // R11: flips written while suspended take effect only next time
    setMode(1'b0);
    runScenario(1'b0, 7, 1'b1, "R11 flip0");
    runScenario(1'b1, 7, 1'b1, "R11 after0");
    runScenario(1'b0, 5, 1'b0, "R11 after1");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule